// File: doc/BRIEF.md
# Precision interval timer

This block is a programmable interval timer attached to an I/O channel that moves either single bytes or 16-bit halfwords. Software fills a 16-bit holding word made of a 4-bit rate code in bits 15:12 and a 12-bit interval count in bits 11:0. It then issues a start command. Start copies the holding word into an active interval register and loads the live count. While the active rate code is nonzero, the live count steps down once per tick of the chosen timebase. When it runs out, the timer reloads both registers from the holding word. It can also post an interrupt.

A built-in prescaler divides the system clock into 1 µs, 10 µs, 100 µs and 1 ms tick enables. The rate code picks one of them by its lowest set bit. Byte transfers are sequenced by separate write and read pointers. An expiry that lands between the two byte writes of a new value raises an overflow flag, which software can detect through a status sense.

Top module: `prec_interval_timer`

## Requirements
- R1: After reset the live count reads 0, a status sense returns 0, `irq` is low, and both interrupt enable and arm are cleared.
- R2: A byte write (`wr_byte`, data in `wr_data[7:0]`) loads the high byte of the holding word when the write pointer is 0 and the low byte when it is 1, then toggles the pointer. A halfword write loads all 16 bits and clears the pointer.
- R3: With `rd_byte` high, `rd_data` returns the high byte of the live count in bits 7:0 when the read pointer is 0 and the low byte when it is 1, and the pointer toggles. Otherwise `rd_data` returns the whole zero-extended live count, and `rd_half` clears the read pointer.
- R4: A command with `cmd_data[5]` set is a start. It copies the holding word into the active interval register and loads the live count from its bits 11:0. It clears the overflow flag and both byte pointers, and restarts the prescaler so that the first tick comes one full period later.
- R5: While the active rate code is 0000 the live count does not change.
- R6: The lowest set bit of the active rate code selects the timebase: bit 0 selects 1 µs, bit 1 selects 10 µs, bit 2 selects 100 µs and bit 3 selects 1 ms. The first decrement after a start comes exactly one timebase period after the start.
- R7: A timebase tick that finds the live count at 1 or 0 is an expiry. An expiry reloads the active interval register and the live count from the holding word, and counting stops if the reloaded rate code is 0000.
- R8: An expiry while the write pointer is 1 sets the overflow flag. A sense (`sense` high) then returns 0x08 on `status` and clears the flag.
- R9: An expiry while armed sets the interrupt request. `irq` is high while the request is pending and enabled, and a sense clears the request.
- R10: Every command updates enable and arm, whether or not it is a start. `cmd_data[0]` sets enable, else `cmd_data[1]` clears it. `cmd_data[2]` sets arm, else `cmd_data[3]` clears it.
- R11: A sense while the overflow flag is clear returns 0x00, including after an expiry that occurred with the write pointer at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_byte | input | 1 | Byte write strobe |
| wr_half | input | 1 | Halfword write strobe |
| wr_data | input | 16 | Write data (bits 7:0 for byte writes) |
| rd_byte | input | 1 | Byte read strobe |
| rd_half | input | 1 | Halfword read strobe |
| rd_data | output | 16 | Live count, or the selected byte during a byte read |
| cmd_valid | input | 1 | Command strobe |
| cmd_data | input | 8 | Command byte (start, enable, arm controls) |
| sense | input | 1 | Status sense strobe |
| status | output | 8 | Sense result, valid while `sense` is high |
| irq | output | 1 | Interrupt level |

## Verification
Counting is exercised under rate codes with a single bit set and under codes with several bits set (0110, 1100, 1111). This separates lowest-set-bit decoding from highest-bit or exact-match decoding, and the exact sampling cycle exposes an off-by-one period in the prescaler. Initial counts of 3 and 0, together with holding words that change while the timer runs, separate reload-from-holding from reload-from-active and show that counting stops on a zero rate. Byte sequences that mix halfword writes distinguish pointer clearing from pointer toggling. Expiries with the write pointer at 1 and at 0 tell whether the overflow flag tracks a half-written value, not every expiry.

// File: rtl/pit_pkg.sv
// Package: shared widths, command bit positions and the holding-word layout
// for the precision interval timer. Assumes a 4-bit rate code over 4 bases.
package pit_pkg;
    localparam int WORD_W    = 16;
    localparam int RATE_W    = 4;
    localparam int CNT_W     = 12;
    localparam int BYTE_W    = 8;
    localparam int CMD_W     = 8;
    localparam int NUM_BASES = 4;
    localparam int BASE_SEL_W = $clog2(NUM_BASES);
    localparam int DECADE    = 10;

    // Command byte bit positions
    localparam int CMD_ENB    = 0;
    localparam int CMD_DIS    = 1;
    localparam int CMD_ARM    = 2;
    localparam int CMD_DISARM = 3;
    localparam int CMD_GO     = 5;

    localparam logic [CMD_W-1:0] SENSE_OVF = 8'h08;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic [CNT_W-1:0]  count;
    } pit_word_t;

    // Lowest set bit of the rate code picks the timebase index
    function automatic logic [BASE_SEL_W-1:0] pick_base(input logic [RATE_W-1:0] r);
        logic [BASE_SEL_W-1:0] idx;
        idx = '0;
        for (int i = RATE_W - 1; i >= 0; i--) begin
            if (r[i]) idx = BASE_SEL_W'(i);
        end
        return idx;
    endfunction
endpackage

// File: rtl/pit_prescaler.sv
// Module: divides the system clock into single-cycle tick enables at 1 us
// and each following decade. Assumes CLKS_PER_US system clocks per us.
// A restart clears every stage so the next tick is a full period away.
module pit_prescaler #(
    parameter int CLKS_PER_US = 200,
    parameter int NUM_BASES   = pit_pkg::NUM_BASES,
    parameter int DECADE      = pit_pkg::DECADE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    output logic [NUM_BASES-1:0] tick
);
    localparam int US_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [US_W-1:0] US_LAST = US_W'(CLKS_PER_US - 1);
    localparam int DEC_W = $clog2(DECADE);
    localparam logic [DEC_W-1:0] DEC_LAST = DEC_W'(DECADE - 1);

    logic [US_W-1:0] us_cnt;

    // Count system clocks within one microsecond
    always_ff @(posedge clk) begin
        if (!rst_n || restart)      us_cnt <= '0;
        else if (us_cnt == US_LAST) us_cnt <= '0;
        else                        us_cnt <= us_cnt + 1'b1;
    end

    assign tick[0] = (us_cnt == US_LAST);

    for (genvar g = 1; g < NUM_BASES; g++) begin : g_decade
        logic [DEC_W-1:0] dcnt;

        // Count ticks of the previous base, wrapping every decade
        always_ff @(posedge clk) begin
            if (!rst_n || restart) dcnt <= '0;
            else if (tick[g-1])    dcnt <= (dcnt == DEC_LAST) ? '0 : dcnt + 1'b1;
        end

        assign tick[g] = tick[g-1] && (dcnt == DEC_LAST);
    end

    if (CLKS_PER_US > 1) begin : g_chk
        // R4: no tick in the cycle right after a restart
        assert_restart_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
            restart |=> (tick == '0));
    end
endmodule

// File: rtl/pit_host_if.sv
// Module: channel side of the timer. Holds the holding word, the byte
// write and read pointers, and forms the read data from the live count.
// Assumes byte data arrives in wr_data[7:0]; halfword strobes win over byte.
module pit_host_if
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_byte,
    input  logic              wr_half,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_byte,
    input  logic              rd_half,
    input  logic              clear_ptrs,
    input  logic [CNT_W-1:0]  cur_count,
    output logic [WORD_W-1:0] hold_word,
    output logic              wr_ptr,
    output logic [WORD_W-1:0] rd_data
);
    logic              rd_ptr;
    logic [WORD_W-1:0] cur_ext;

    // Load the holding word and step the write pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_word <= '0;
            wr_ptr    <= 1'b0;
        end else begin
            if (wr_half) begin
                hold_word <= wr_data;
                wr_ptr    <= 1'b0;
            end else if (wr_byte) begin
                if (wr_ptr) hold_word[BYTE_W-1:0]      <= wr_data[BYTE_W-1:0];
                else        hold_word[WORD_W-1:BYTE_W] <= wr_data[BYTE_W-1:0];
                wr_ptr <= ~wr_ptr;
            end
            if (clear_ptrs) wr_ptr <= 1'b0;
        end
    end

    // Step the read pointer on byte reads
    always_ff @(posedge clk) begin
        if (!rst_n)             rd_ptr <= 1'b0;
        else if (clear_ptrs)    rd_ptr <= 1'b0;
        else if (rd_half)       rd_ptr <= 1'b0;
        else if (rd_byte)       rd_ptr <= ~rd_ptr;
    end

    // Select the whole count or one of its bytes for the channel
    always_comb begin
        cur_ext = WORD_W'(cur_count);
        if (rd_byte && !rd_half)
            rd_data = rd_ptr ? {{BYTE_W{1'b0}}, cur_ext[BYTE_W-1:0]}
                             : {{BYTE_W{1'b0}}, cur_ext[WORD_W-1:BYTE_W]};
        else
            rd_data = cur_ext;
    end

    // R2: halfword write leaves the write pointer at zero
    assert_half_clears_wptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_half |=> !wr_ptr);
    // R2: a lone byte write flips the write pointer
    assert_byte_flips_wptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte && !wr_half && !clear_ptrs) |=> (wr_ptr != $past(wr_ptr)));
    // R3: halfword read leaves the read pointer at zero
    assert_half_clears_rptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_half |=> !rd_ptr);
    // R4: start clears both pointers
    assert_start_clears_ptrs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear_ptrs |=> (!wr_ptr && !rd_ptr));
endmodule

// File: rtl/pit_counter.sv
// Module: active interval register and live count. Decrements on the tick
// picked by the lowest set bit of the active rate, reloads from the holding
// word on expiry. Assumes start has priority over a tick in the same cycle.
module pit_counter
    import pit_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [WORD_W-1:0]    hold_word,
    input  logic [NUM_BASES-1:0] tick,
    output logic [CNT_W-1:0]     cur_count,
    output logic                 expire
);
    pit_word_t active;
    pit_word_t hold;
    logic      running;
    logic      sel_tick;

    assign hold     = pit_word_t'(hold_word);
    assign running  = (active.rate != '0);
    assign sel_tick = tick[pick_base(active.rate)];
    assign expire   = running && sel_tick && !start && (cur_count <= CNT_W'(1));

    // Load on start, step down on the selected tick, reload on expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= '0;
            cur_count <= '0;
        end else if (start) begin
            active    <= hold;
            cur_count <= hold.count;
        end else if (running && sel_tick) begin
            if (cur_count <= CNT_W'(1)) begin
                active    <= hold;
                cur_count <= hold.count;
            end else begin
                cur_count <= cur_count - 1'b1;
            end
        end
    end

    // R4: start copies the holding word
    assert_start_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (active == $past(hold)));
    // R5: a stopped timer keeps its count
    assert_stopped_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start) |=> $stable(cur_count));
    // R7: expiry reloads the live count from the holding word
    assert_expire_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cur_count == $past(hold.count)));
endmodule

// File: rtl/pit_irq_ctl.sv
// Module: enable and arm flops, overflow flag, interrupt request and the
// sense-status result. Assumes a new expiry wins over a sense in one cycle.
module pit_irq_ctl
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_data,
    input  logic             start,
    input  logic             expire,
    input  logic             wr_ptr,
    input  logic             sense,
    output logic [CMD_W-1:0] status,
    output logic             irq
);
    logic enb, arm, ovf, req;

    // Update enable and arm on every command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enb <= 1'b0;
            arm <= 1'b0;
        end else if (cmd_valid) begin
            if (cmd_data[CMD_ENB])         enb <= 1'b1;
            else if (cmd_data[CMD_DIS])    enb <= 1'b0;
            if (cmd_data[CMD_ARM])         arm <= 1'b1;
            else if (cmd_data[CMD_DISARM]) arm <= 1'b0;
        end
    end

    // Track a half-written value caught by an expiry
    always_ff @(posedge clk) begin
        if (!rst_n) ovf <= 1'b0;
        else begin
            if (start || sense)    ovf <= 1'b0;
            if (expire && wr_ptr)  ovf <= 1'b1;
        end
    end

    // Hold the interrupt request until sensed
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else begin
            if (sense)         req <= 1'b0;
            if (expire && arm) req <= 1'b1;
        end
    end

    assign irq    = req && enb;
    assign status = (sense && ovf) ? SENSE_OVF : '0;

    // R9: request only rises from an armed expiry
    assert_req_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(expire && arm));
    // R8: overflow only rises from an expiry with the write pointer at 1
    assert_ovf_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(expire && wr_ptr));
    // R8: sense without a new expiry clears flag and request
    assert_sense_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sense && !expire) |=> (!ovf && !req));
endmodule

// File: rtl/prec_interval_timer.sv
// Module: top of the precision interval timer. Wires the channel side,
// prescaler, counter and interrupt control. Assumes one strobe per cycle
// from a well-behaved channel; a start command is cmd_valid with bit 5.
module prec_interval_timer
    import pit_pkg::*;
#(
    parameter int CLKS_PER_US = 200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_byte,
    input  logic        wr_half,
    input  logic [15:0] wr_data,
    input  logic        rd_byte,
    input  logic        rd_half,
    output logic [15:0] rd_data,
    input  logic        cmd_valid,
    input  logic [7:0]  cmd_data,
    input  logic        sense,
    output logic [7:0]  status,
    output logic        irq
);
    logic                 start;
    logic [WORD_W-1:0]    hold_word;
    logic                 wr_ptr;
    logic [CNT_W-1:0]     cur_count;
    logic                 expire;
    logic [NUM_BASES-1:0] tick;

    assign start = cmd_valid && cmd_data[CMD_GO];

    pit_host_if u_host (
        .clk(clk), .rst_n(rst_n),
        .wr_byte(wr_byte), .wr_half(wr_half), .wr_data(wr_data),
        .rd_byte(rd_byte), .rd_half(rd_half), .clear_ptrs(start),
        .cur_count(cur_count), .hold_word(hold_word), .wr_ptr(wr_ptr),
        .rd_data(rd_data)
    );

    pit_prescaler #(.CLKS_PER_US(CLKS_PER_US)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(start), .tick(tick)
    );

    pit_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .start(start), .hold_word(hold_word),
        .tick(tick), .cur_count(cur_count), .expire(expire)
    );

    pit_irq_ctl u_irq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .start(start), .expire(expire), .wr_ptr(wr_ptr), .sense(sense),
        .status(status), .irq(irq)
    );
endmodule

// File: tb/prec_interval_timer_test.sv
`timescale 1ns/1ps
module prec_interval_timer_test;
    localparam int CPU = 2;   // system clocks per microsecond in this bench

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_byte = 1'b0, wr_half = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_byte = 1'b0, rd_half = 1'b0;
    logic [15:0] rd_data;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_data = '0;
    logic        sense = 1'b0;
    logic [7:0]  status;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    prec_interval_timer #(.CLKS_PER_US(CPU)) uut (
        .clk(clk), .rst_n(rst_n), .wr_byte(wr_byte), .wr_half(wr_half),
        .wr_data(wr_data), .rd_byte(rd_byte), .rd_half(rd_half),
        .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .sense(sense), .status(status), .irq(irq)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
        end
    endtask

    // All drivers start and end at a falling edge
    task automatic put_half(input logic [15:0] d);
        wr_half = 1'b1; wr_data = d;
        @(negedge clk); wr_half = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        wr_byte = 1'b1; wr_data = {8'h00, b};
        @(negedge clk); wr_byte = 1'b0;
    endtask

    task automatic command(input logic [7:0] c);
        cmd_valid = 1'b1; cmd_data = c;
        @(negedge clk); cmd_valid = 1'b0; cmd_data = '0;
    endtask

    task automatic do_sense(input string tag, input logic [7:0] exp);
        sense = 1'b1; #1;
        check(tag, 16'(status), 16'(exp));
        @(negedge clk); sense = 1'b0;
    endtask

    task automatic read_byte(input string tag, input logic [15:0] exp);
        rd_byte = 1'b1; #1;
        check(tag, rd_data, exp);
        @(negedge clk); rd_byte = 1'b0;
    endtask

    task automatic read_half(input string tag, input logic [15:0] exp);
        rd_half = 1'b1; #1;
        check(tag, rd_data, exp);
        @(negedge clk); rd_half = 1'b0;
    endtask

    task automatic test_reset;
        check("R1 count after reset", rd_data, 16'h0000);
        check("R1 irq after reset", 16'(irq), 16'h0000);
        do_sense("R1 status after reset", 8'h00);
    endtask

    task automatic test_bytes;
        // R2: high then low byte via the write pointer
        put_byte(8'h0A); put_byte(8'hBC);
        command(8'h20);
        check("R2 byte pair load", rd_data, 16'h0ABC);
        // R3: byte reads high, low, then halfword read clears pointer
        read_byte("R3 first byte high", 16'h000A);
        read_byte("R3 second byte low", 16'h00BC);
        read_half("R3 halfword read", 16'h0ABC);
        read_byte("R3 pointer cleared by halfword", 16'h000A);
        // R2: halfword write clears a half-open pointer
        put_byte(8'hFF); put_half(16'h0055); put_byte(8'h07); put_byte(8'h66);
        command(8'h20);
        check("R2 halfword clears pointer", rd_data, 16'h0766);
    endtask

    task automatic test_stopped;
        put_half(16'h0123); command(8'h20);
        repeat (100) @(negedge clk);
        check("R5 rate zero holds count", rd_data, 16'h0123);
    endtask

    task automatic run_base(input logic [3:0] rate, input int period_us, input string tag);
        put_half({rate, 12'd5});
        command(8'h20);
        repeat (CPU * period_us - 1) @(negedge clk);
        check({tag, " before first tick"}, rd_data, 16'h0005);
        @(negedge clk);
        check({tag, " at first tick"}, rd_data, 16'h0004);
    endtask

    task automatic test_bases;
        run_base(4'b0001, 1,    "R6 rate 0001 1us");
        run_base(4'b0010, 10,   "R6 rate 0010 10us");
        run_base(4'b0100, 100,  "R6 rate 0100 100us");
        run_base(4'b1000, 1000, "R6 rate 1000 1ms");
        run_base(4'b0110, 10,   "R6 rate 0110 10us");
        run_base(4'b1100, 100,  "R6 rate 1100 100us");
        run_base(4'b1111, 1,    "R6 rate 1111 1us");
    endtask

    task automatic test_reload;
        put_half(16'h1003); command(8'h20);
        put_half(16'h1002);
        repeat (4) @(negedge clk);
        check("R7 count one before expiry", rd_data, 16'h0001);
        @(negedge clk);
        check("R7 reload from holding word", rd_data, 16'h0002);
        put_half(16'h0007);
        repeat (3) @(negedge clk);
        check("R7 reload with zero rate", rd_data, 16'h0007);
        repeat (30) @(negedge clk);
        check("R7 stops after zero-rate reload", rd_data, 16'h0007);
        // count 0 expires at the first tick
        put_half(16'h1000); command(8'h20);
        put_half(16'h0009);
        check("R7 zero count before tick", rd_data, 16'h0000);
        @(negedge clk);
        check("R7 zero count expires on first tick", rd_data, 16'h0009);
    endtask

    task automatic test_overflow;
        do_sense("R11 sense with no overflow", 8'h00);
        put_half(16'h1002); command(8'h20);
        put_byte(8'h10);                    // write pointer now 1
        repeat (3) @(negedge clk);          // expiry has happened
        do_sense("R8 overflow sensed", 8'h08);
        do_sense("R8 overflow cleared by sense", 8'h00);
        repeat (3) @(negedge clk);          // another expiry with pointer at 1
        command(8'h20);
        do_sense("R4 start clears overflow", 8'h00);
        repeat (5) @(negedge clk);          // expiry with pointer at 0
        do_sense("R11 expiry with pointer 0", 8'h00);
    endtask

    task automatic test_irq;
        put_half(16'h0000); command(8'h20);
        command(8'h05);                     // enable + arm, no start
        check("R10 no irq without expiry", 16'(irq), 16'h0000);
        put_half(16'h1002); command(8'h20);
        put_half(16'h0002);
        repeat (3) @(negedge clk);
        check("R9 armed expiry raises irq", 16'(irq), 16'h0001);
        command(8'h02);
        check("R10 disable masks irq", 16'(irq), 16'h0000);
        command(8'h01);
        check("R10 enable restores irq", 16'(irq), 16'h0001);
        do_sense("R8 no overflow in irq test", 8'h00);
        check("R9 sense clears irq", 16'(irq), 16'h0000);
        put_half(16'h1001); command(8'h28);  // start + disarm
        repeat (6) @(negedge clk);
        check("R10 disarmed expiry no irq", 16'(irq), 16'h0000);
        put_half(16'h0000); command(8'h20);
    endtask

    task automatic test_reset_midrun;
        command(8'h05);
        put_half(16'h1003); command(8'h20);
        repeat (10) @(negedge clk);
        rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
        check("R1 reset clears count", rd_data, 16'h0000);
        check("R1 reset clears irq", 16'(irq), 16'h0000);
        command(8'h04);                     // arm only; enable stays cleared
        put_half(16'h1001); command(8'h20);
        repeat (6) @(negedge clk);
        check("R1 reset cleared enable", 16'(irq), 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_bytes();
        test_stopped();
        test_bases();
        test_reload();
        test_overflow();
        test_irq();
        test_reset_midrun();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule